// File: doc/BRIEF.md
# Serial SAR ADC Readout Controller

This block runs on the host side of a serial successive-approximation converter. It divides the system clock down to the converter's master clock. It starts a conversion at a fixed rate, counted in master-clock periods. It also frames the serial readout, in one of two ways:

- **Mode 0:** the convert-start line itself frames the data.
- **Mode 1:** a separate active-low frame-sync line frames the data.

The converter returns a serial clock that is derived from the master clock, together with a 16-bit word. The word holds the result of the previous conversion. The controller shifts that word in and presents the overrange flag and the 14-bit code with a one-cycle strobe. It also raises a framing-error flag when the trailing bit is not zero.

A low-power request stops new conversions at the next sample boundary. On release, the controller waits a settling interval before it starts converting again. Because readout is one sample behind, the first word after reset or after leaving low power carries a stale result. That word is dropped and reported on a separate strobe instead of the valid strobe.

Top module: `adc_rd_ctrl`

## Requirements
- R1: `adc_clk_o` has a period of 2*ADC_CLK_HALF system clocks, with equal high and low times.
- R2: While running, `conv_n_o` falls once every SAMPLE_PER master-clock periods, on a system-clock edge where `adc_clk_o` falls. `conv_n_o` is high during reset.
- R3: In mode 0 (`frame_sel_i`=0), `conv_n_o` stays low for exactly FRAME_LEN master-clock periods per sample, and `frm_n_o` is held low.
- R4: In mode 1 (`frame_sel_i`=1), `conv_n_o` is low for exactly one master-clock period. `frm_n_o` falls on the same edge and stays low for FRAME_LEN periods. The mode is taken at the start of each frame, so a change during a frame takes effect with the next frame.
- R5: In each frame the controller skips the serial-clock falling edges that come before the first rising edge. It then samples 16 bits on the next 16 falling edges, first bit first. Bit 15 (first received) is the overrange flag, bits 14..1 are the code with the MSB first, and bit 0 is the trailing bit.
- R6: Each accepted word is presented with a one-cycle `res_valid_o` pulse. Each word holds the result of the conversion started one sample earlier.
- R7: `res_ferr_o` accompanies each word and is 1 exactly when the trailing bit was 1.
- R8: The first word captured after reset, or after leaving low power, raises `res_drop_o` for one cycle and never raises `res_valid_o`.
- R9: While `low_pwr_i` is high at a sample boundary, no conversion starts and `conv_n_o` stays high. A frame already in progress completes and delivers its word.
- R10: After `low_pwr_i` falls, the first `conv_n_o` fall comes between WAKE_LEN and WAKE_LEN+1 master-clock periods later.
- R11: `res_valid_o` and `res_drop_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_sel_i | input | 1 | Framing mode: 0 = convert-start frames the data, 1 = separate frame sync |
| low_pwr_i | input | 1 | Low-power request; stops new conversions |
| adc_clk_o | output | 1 | Divided master clock to the converter |
| conv_n_o | output | 1 | Active-low convert start; a conversion begins on its falling edge |
| frm_n_o | output | 1 | Active-low frame sync for mode 1; held low in mode 0 |
| ser_clk_i | input | 1 | Serial clock returned by the converter |
| ser_dat_i | input | 1 | Serial data; changes on the rising edge of ser_clk_i |
| res_valid_o | output | 1 | One-cycle strobe for an accepted word |
| res_drop_o | output | 1 | One-cycle strobe for a discarded stale word |
| res_ovr_o | output | 1 | Overrange flag of the last word |
| res_code_o | output | 14 | 14-bit code of the last word |
| res_ferr_o | output | 1 | Trailing bit of the last word was 1 |

## Verification
The bench builds the block with ADC_CLK_HALF=2, SAMPLE_PER=32, FRAME_LEN=24 and WAKE_LEN=6. With these values a sample takes only 128 system clocks, so one short run covers:

- a dozen or more frames in both framing modes;
- two wake-up discards and a sleep interval;
- a mode change in the middle of a frame.

At HALF=2 the serial clock is oversampled with the smallest margin the synchronizer allows. This exposes the case where a stale rising edge is detected in the same cycle that a new frame starts. A responder model returns the previous sample's word and marks one word with a set trailing bit. The sample values include both overrange states.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  localparam int WORD_W = 16;
  localparam int CODE_W = 14;

  typedef enum logic [1:0] {
    SQ_WAKE  = 2'd0,
    SQ_RUN   = 2'd1,
    SQ_SLEEP = 2'd2
  } seq_st_e;

  typedef struct packed {
    logic              ovr;
    logic [CODE_W-1:0] code;
    logic              trail;
  } adc_word_t;

endpackage

// File: rtl/adc_rd_clkgen.sv
module adc_rd_clkgen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic adc_clk_o,
  output logic fall_tick_o
);

  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(HALF - 1));

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    lvl_d = wrap ? ~lvl_q : lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign adc_clk_o   = lvl_q;
  // high in the cycle whose closing edge drives the master clock low
  assign fall_tick_o = wrap & lvl_q;

endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int SAMPLE_PER = 32,
  parameter int FRAME_LEN  = 24,
  parameter int WAKE_LEN   = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic frame_sel_i,
  input  logic low_pwr_i,
  output logic conv_n_o,
  output logic frm_n_o,
  output logic start_o,
  output logic discard_o
);

  localparam int PH_W = (SAMPLE_PER > 1) ? $clog2(SAMPLE_PER) : 1;
  localparam int WK_W = $clog2(WAKE_LEN + 1);

  seq_st_e          st_q, st_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic [WK_W-1:0]  wk_q, wk_d;
  logic             mode_q, mode_d;
  logic             first_q, first_d;
  logic             disc_q, disc_d;
  logic             start_q;
  logic             conv_q, conv_d;
  logic             frm_q, frm_d;
  logic             launch, in_frame;

  always_comb begin
    launch = tick_i & ~low_pwr_i &
             (((st_q == SQ_WAKE) && (wk_q == WK_W'(WAKE_LEN - 1))) ||
              ((st_q == SQ_RUN)  && (ph_q == PH_W'(SAMPLE_PER - 1))));
  end

  always_comb begin
    st_d    = st_q;
    ph_d    = ph_q;
    wk_d    = wk_q;
    mode_d  = mode_q;
    first_d = first_q;
    disc_d  = disc_q;
    if (launch) begin
      st_d    = SQ_RUN;
      ph_d    = '0;
      mode_d  = frame_sel_i;
      disc_d  = first_q;
      first_d = 1'b0;
    end else if (tick_i) begin
      unique case (st_q)
        SQ_WAKE: begin
          if (low_pwr_i) st_d = SQ_SLEEP;
          else           wk_d = wk_q + 1'b1;
        end
        SQ_RUN: begin
          if (ph_q == PH_W'(SAMPLE_PER - 1)) st_d = SQ_SLEEP;
          else                               ph_d = ph_q + 1'b1;
        end
        SQ_SLEEP: begin
          if (!low_pwr_i) begin
            st_d    = SQ_WAKE;
            wk_d    = '0;
            first_d = 1'b1;
          end
        end
        default: st_d = SQ_WAKE;
      endcase
    end
  end

  // outputs follow the next state so they change on the tick edge itself
  always_comb begin
    in_frame = (st_d == SQ_RUN) && (ph_d < PH_W'(FRAME_LEN));
    if (mode_d) begin
      conv_d = ~((st_d == SQ_RUN) && (ph_d == '0));
      frm_d  = ~in_frame;
    end else begin
      conv_d = ~in_frame;
      frm_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_WAKE;
      ph_q    <= '0;
      wk_q    <= '0;
      mode_q  <= 1'b0;
      first_q <= 1'b1;
      disc_q  <= 1'b0;
      start_q <= 1'b0;
      conv_q  <= 1'b1;
      frm_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      ph_q    <= ph_d;
      wk_q    <= wk_d;
      mode_q  <= mode_d;
      first_q <= first_d;
      disc_q  <= disc_d;
      start_q <= launch;
      conv_q  <= conv_d;
      frm_q   <= frm_d;
    end
  end

  assign conv_n_o  = conv_q;
  assign frm_n_o   = frm_q;
  assign start_o   = start_q;
  assign discard_o = disc_q;

endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture
  import adc_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o
);

  localparam int BC_W = $clog2(WORD_W);

  logic              sc1_q, sc2_q, scd_q;
  logic              sd1_q, sd2_q;
  logic              busy_q, busy_d;
  logic              seen_q, seen_d;
  logic [BC_W-1:0]   cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              done_q, done_d;
  logic              rise, fall;

  assign rise = sc2_q & ~scd_q;
  assign fall = ~sc2_q & scd_q;

  always_comb begin
    busy_d = busy_q;
    seen_d = seen_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    if (start_i) begin
      busy_d = 1'b1;
      seen_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (rise) seen_d = 1'b1;
      if (fall && seen_q) begin
        sh_d = {sh_q[WORD_W-2:0], sd2_q};
        if (cnt_q == BC_W'(WORD_W - 1)) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc1_q  <= 1'b0;
      sc2_q  <= 1'b0;
      scd_q  <= 1'b0;
      sd1_q  <= 1'b0;
      sd2_q  <= 1'b0;
      busy_q <= 1'b0;
      seen_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      sc1_q  <= ser_clk_i;
      sc2_q  <= sc1_q;
      scd_q  <= sc2_q;
      sd1_q  <= ser_dat_i;
      sd2_q  <= sd1_q;
      busy_q <= busy_d;
      seen_q <= seen_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
  assign word_o = sh_q;

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int ADC_CLK_HALF = 2,
  parameter int SAMPLE_PER   = 32,
  parameter int FRAME_LEN    = 24,
  parameter int WAKE_LEN     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sel_i,
  input  logic              low_pwr_i,
  output logic              adc_clk_o,
  output logic              conv_n_o,
  output logic              frm_n_o,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  output logic              res_valid_o,
  output logic              res_drop_o,
  output logic              res_ovr_o,
  output logic [CODE_W-1:0] res_code_o,
  output logic              res_ferr_o
);

  logic [1:0]        rs_q;
  logic              rst_s_n;
  logic              tick, start, discard, done;
  logic [WORD_W-1:0] word;
  adc_word_t         w;
  logic              val_q, val_d, drp_q, drp_d;
  logic              ovr_q, ovr_d, ferr_q, ferr_d;
  logic [CODE_W-1:0] code_q, code_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  adc_rd_clkgen #(.HALF(ADC_CLK_HALF)) u_clkgen (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .adc_clk_o   (adc_clk_o),
    .fall_tick_o (tick)
  );

  adc_rd_seq #(
    .SAMPLE_PER (SAMPLE_PER),
    .FRAME_LEN  (FRAME_LEN),
    .WAKE_LEN   (WAKE_LEN)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .tick_i      (tick),
    .frame_sel_i (frame_sel_i),
    .low_pwr_i   (low_pwr_i),
    .conv_n_o    (conv_n_o),
    .frm_n_o     (frm_n_o),
    .start_o     (start),
    .discard_o   (discard)
  );

  adc_rd_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .start_i   (start),
    .ser_clk_i (ser_clk_i),
    .ser_dat_i (ser_dat_i),
    .done_o    (done),
    .word_o    (word)
  );

  assign w = adc_word_t'(word);

  always_comb begin
    val_d  = done & ~discard;
    drp_d  = done &  discard;
    ovr_d  = done ? w.ovr   : ovr_q;
    code_d = done ? w.code  : code_q;
    ferr_d = done ? w.trail : ferr_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      val_q  <= 1'b0;
      drp_q  <= 1'b0;
      ovr_q  <= 1'b0;
      code_q <= '0;
      ferr_q <= 1'b0;
    end else begin
      val_q  <= val_d;
      drp_q  <= drp_d;
      ovr_q  <= ovr_d;
      code_q <= code_d;
      ferr_q <= ferr_d;
    end
  end

  assign res_valid_o = val_q;
  assign res_drop_o  = drp_q;
  assign res_ovr_o   = ovr_q;
  assign res_code_o  = code_q;
  assign res_ferr_o  = ferr_q;

endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
  parameter int ADC_CLK_HALF = 2
) (
  input logic clk,
  input logic rst_n,
  input logic low_pwr_i,
  input logic adc_clk_o,
  input logic conv_n_o,
  input logic frm_n_o,
  input logic res_valid_o,
  input logic res_drop_o
);

  logic        prev_q, seen_q;
  logic [15:0] hcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
      hcnt_q <= '0;
    end else begin
      prev_q <= adc_clk_o;
      if (adc_clk_o != prev_q) begin
        hcnt_q <= '0;
        seen_q <= 1'b1;
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

  p_adc_clk_half_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && (adc_clk_o != prev_q)) |-> (hcnt_q == 16'(ADC_CLK_HALF - 1)));

  p_frm_with_conv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frm_n_o) |-> $fell(conv_n_o));

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |=> !res_valid_o);

  p_no_start_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(low_pwr_i) && $past(conv_n_o)) |-> conv_n_o);

  p_valid_drop_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_valid_o, res_drop_o}));

endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(.ADC_CLK_HALF(ADC_CLK_HALF)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .low_pwr_i   (low_pwr_i),
  .adc_clk_o   (adc_clk_o),
  .conv_n_o    (conv_n_o),
  .frm_n_o     (frm_n_o),
  .res_valid_o (res_valid_o),
  .res_drop_o  (res_drop_o)
);

// File: tb/adc_rd_ctrl_tb.sv
module adc_rd_ctrl_tb;

  localparam int HALF = 2;
  localparam int SPER = 32;
  localparam int FLEN = 24;
  localparam int WLEN = 6;
  localparam int PER  = 2 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_sel = 1'b0;
  logic        low_pwr = 1'b0;
  logic        adc_clk, conv_n, frm_n, ser_clk;
  logic        ser_dat = 1'b1;
  logic        res_valid, res_drop, res_ovr, res_ferr;
  logic [13:0] res_code;

  assign ser_clk = adc_clk;

  adc_rd_ctrl #(
    .ADC_CLK_HALF (HALF),
    .SAMPLE_PER   (SPER),
    .FRAME_LEN    (FLEN),
    .WAKE_LEN     (WLEN)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_sel_i (frame_sel),
    .low_pwr_i   (low_pwr),
    .adc_clk_o   (adc_clk),
    .conv_n_o    (conv_n),
    .frm_n_o     (frm_n),
    .ser_clk_i   (ser_clk),
    .ser_dat_i   (ser_dat),
    .res_valid_o (res_valid),
    .res_drop_o  (res_drop),
    .res_ovr_o   (res_ovr),
    .res_code_o  (res_code),
    .res_ferr_o  (res_ferr)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(negedge clk) cyc++;

  int checks = 0;
  int fails  = 0;

  task automatic chk_eq(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_ok(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic logic [14:0] mk(int k);
    return 15'((k * 11213) ^ 32'h4C31);
  endfunction

  // converter responder and scoreboard driver
  bit [16:0]   expq[$];
  logic [15:0] prev_w = 16'hFFFF;
  logic [15:0] cur_w  = 16'h0000;
  int          bidx = 16;
  int          ksamp = 0;
  int          nfall = 0;
  bit          tb_mode = 1'b0;
  bit          drop_next = 1'b1;
  bit          inject_next = 1'b0;

  always @(negedge conv_n) begin
    nfall++;
    tb_mode = frame_sel;
    expq.push_back({drop_next, prev_w});
    drop_next = 1'b0;
    cur_w = prev_w;
    prev_w = {mk(ksamp), inject_next};
    inject_next = 1'b0;
    ksamp++;
    bidx = 0;
  end

  always @(posedge ser_clk) begin
    if ((tb_mode ? !frm_n : !conv_n) && bidx < 16) begin
      ser_dat = cur_w[15 - bidx];
      bidx++;
    end else begin
      ser_dat = 1'b1;
    end
  end

  // monitor
  int ovr_seen = 0, nonovr_seen = 0, ferr_seen = 0, both_seen = 0;
  always @(negedge clk) begin
    if (res_valid && res_drop) both_seen++;
    if (res_valid || res_drop) begin
      if (expq.size() == 0) begin
        chk_ok(1'b0, "R6", "result with nothing expected", 1, 0);
      end else begin
        automatic bit [16:0] e = expq.pop_front();
        if (e[16]) begin
          chk_eq("R8", "drop strobe on stale word", res_drop, 1);
          chk_eq("R8", "valid on stale word", res_valid, 0);
        end else begin
          chk_eq("R6", "valid strobe", res_valid, 1);
          chk_eq("R5", "overrange bit", res_ovr, e[15]);
          chk_eq("R5", "code", res_code, e[14:1]);
          chk_eq("R7", "frame error flag", res_ferr, e[0]);
          if (e[15]) ovr_seen++; else nonovr_seen++;
          if (e[0]) ferr_seen++;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk_ok(1'b0, "R2", "watchdog expired", cyc, 0);
    finish_up();
  end

  initial begin
    int t0, t1, n0;
    repeat (5) @(negedge clk);
    chk_eq("R2", "convert start idle in reset", conv_n, 1);
    chk_eq("R6", "valid in reset", res_valid, 0);
    rst_n = 1'b1;

    @(posedge adc_clk); t0 = cyc;
    @(posedge adc_clk);
    chk_eq("R1", "master clock period", cyc - t0, PER);
    @(negedge adc_clk); t0 = cyc;
    @(posedge adc_clk);
    chk_eq("R1", "master clock low time", cyc - t0, HALF);

    // mode 0 framing
    @(negedge conv_n); t0 = cyc;
    chk_eq("R2", "start aligned with master clock fall", adc_clk, 0);
    @(posedge conv_n);
    chk_eq("R3", "convert start low width", cyc - t0, FLEN * PER);
    chk_eq("R3", "frame sync held low", frm_n, 0);
    @(negedge conv_n);
    chk_eq("R2", "sample spacing", cyc - t0, SPER * PER);
    repeat (4) @(negedge conv_n);

    // low power
    repeat (8) @(negedge clk);
    low_pwr = 1'b1;
    n0 = nfall;
    repeat (3 * SPER * PER) @(negedge clk);
    chk_eq("R9", "starts during low power", nfall - n0, 0);
    chk_eq("R9", "convert start idle in low power", conv_n, 1);
    chk_eq("R9", "frame in progress delivered", expq.size(), 0);
    frame_sel = 1'b1;

    // wake into mode 1
    @(negedge clk);
    #1;
    low_pwr = 1'b0;
    drop_next = 1'b1;
    t0 = cyc;
    @(negedge conv_n); t1 = cyc;
    #1;
    chk_ok((t1 - t0) >= WLEN * PER - 1 && (t1 - t0) <= (WLEN + 1) * PER + 1,
           "R10", "wake delay", t1 - t0, WLEN * PER);
    chk_eq("R4", "frame sync falls with convert start", frm_n, 0);
    @(posedge conv_n);
    chk_eq("R4", "convert start pulse width", cyc - t1, PER);
    @(posedge frm_n);
    chk_eq("R4", "frame sync low width", cyc - t1, FLEN * PER);
    inject_next = 1'b1;
    repeat (4) @(negedge conv_n);

    // mode change inside a frame
    @(negedge conv_n);
    @(posedge conv_n);
    #1;
    frame_sel = 1'b0;
    repeat (4 * PER) @(negedge clk);
    chk_eq("R4", "mode held for current frame (convert start)", conv_n, 1);
    chk_eq("R4", "mode held for current frame (frame sync)", frm_n, 0);
    @(negedge conv_n); t0 = cyc;
    @(posedge conv_n);
    chk_eq("R3", "new mode at next frame", cyc - t0, FLEN * PER);
    repeat (3) @(negedge conv_n);

    // drain
    repeat (8) @(negedge clk);
    low_pwr = 1'b1;
    repeat (2 * SPER * PER) @(negedge clk);
    chk_eq("R6", "pending results after drain", expq.size(), 0);
    chk_ok(ovr_seen > 0, "R5", "words with overrange set", ovr_seen, 1);
    chk_ok(nonovr_seen > 0, "R5", "words with overrange clear", nonovr_seen, 1);
    chk_ok(ferr_seen > 0, "R7", "framing errors reported", ferr_seen, 1);
    chk_eq("R11", "valid and drop together", both_seen, 0);
    finish_up();
  end

endmodule